// File: doc/BRIEF.md
# Enable-Latched Byte Static Memory

This block is a 2048-byte static memory with an 8-bit data path, built for a clocked core that talks to a narrow multiplexed bus. An 11-bit address is not watched continuously. It is captured into an internal register on the clock edge where the active-low chip enable is first seen low. From then on the address pins are free to carry other traffic, such as write data on a shared address/data bus, until chip enable goes high again.

Reads and writes both act on the captured address. A write is committed when the active-low write enable returns high while chip enable is held low. A read presents the stored byte one clock after the access is established. The data-out bus and its drive flag stand in for a tri-state byte bus. The flag is cut off at once by chip enable high, by output enable high or by write enable low, so software can park the bus without ending the access. The surrounding bus model resolves the flag into actual pin drive.

Top module: `latched_byte_sram`

## Requirements
- R1: The memory holds 2048 independent bytes. A byte written to one address is read back unchanged, and writes to other addresses do not disturb it.
- R2: The address is captured at a clock edge where `ce_n_i` is 0 and was 1 at the previous edge, or where reset has just been released. Changes on `addr_i` after that edge have no effect until `ce_n_i` has returned to 1 and fallen again.
- R3: While `ce_n_i` is 1, `drive_o` is 0 in the same cycle. Whenever `drive_o` is 0, `rdata_o` is all zeros.
- R4: While `oe_n_i` is 1, `drive_o` is 0 in the same cycle, whatever `ce_n_i` is. Returning `oe_n_i` to 0 during an access restores the drive without a new chip-enable pulse.
- R5: A write commits `wdata_i`, as sampled at the committing edge, to the captured address. The committing edge is one where `we_n_i` is 1 after being 0 at the previous edge, with `ce_n_i` 0 at both of those edges.
- R6: `drive_o` is 1 and `rdata_o` holds the byte at the captured address in the cycle after an edge at which all of these hold: `ce_n_i` is 0 at that edge and at the edge before it, `oe_n_i` is 0, and `we_n_i` is 1. This lasts while `ce_n_i` and `oe_n_i` stay 0 and `we_n_i` stays 1. It never happens in the cycle right after the capture edge.
- R7: `drive_o` is 0 while `we_n_i` is 0, even with `oe_n_i` at 0. A write-enable pulse made while `ce_n_i` is 1 changes no stored byte.
- R8: A read that follows a write in the same access returns the newly written byte in the cycle right after the committing edge.
- R9: After reset, `drive_o` is 0 and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 11 | Byte address, captured at the chip-enable fall |
| ce_n_i | input | 1 | Active-low chip enable |
| we_n_i | input | 1 | Active-low write enable |
| oe_n_i | input | 1 | Active-low output enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when not driving |
| drive_o | output | 1 | Output-drive flag for the byte bus |

## Verification
A write commit and the read capture can land on the same clock edge. This happens when an access holds output enable low through a write pulse, so the edge where write enable rises both stores the byte and loads the read register. The bench provokes this in one chip-enable window and requires the new byte on `rdata_o` in the very next cycle, not the value the array held before the write. The same test confirms that `drive_o` stays low while write enable is low.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int ADDR_W_DEF = 11;
  localparam int DATA_W_DEF = 8;

  // Falling level between two consecutive samples.
  function automatic logic fell(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // Rising level between two consecutive samples.
  function automatic logic rose(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction
endpackage

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  output logic [ADDR_W-1:0] addr_lat_o,
  output logic              ce_fall_o,
  output logic              acc_act_o,
  output logic              wr_commit_o
);
  logic ce_q;
  logic we_q;
  logic [ADDR_W-1:0] addr_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b1;
      we_q <= 1'b1;
    end else begin
      ce_q <= ce_n_i;
      we_q <= we_n_i;
    end
  end

  assign ce_fall_o   = fell(ce_q, ce_n_i);
  assign acc_act_o   = ~ce_q & ~ce_n_i;
  assign wr_commit_o = acc_act_o & rose(we_q, we_n_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_lat <= '0;
    else if (ce_fall_o) addr_lat <= addr_i;
  end

  assign addr_lat_o = addr_lat;
endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              bypass;

  assign bypass = wr_en && (wr_addr == rd_addr);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data_q <= '0;
    else if (bypass) rd_data_q <= wr_data;
    else             rd_data_q <= mem[rd_addr];
  end
endmodule

// File: rtl/sram_outdrv.sv
module sram_outdrv
  import sram_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_act,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [DATA_W-1:0] rd_data_q,
  output logic              drive_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= acc_act & ~oe_n_i & we_n_i;
  end

  assign drive_o = drv_q & ~ce_n_i & ~oe_n_i & we_n_i;
  assign rdata_o = drive_o ? rd_data_q : '0;
endmodule

// File: rtl/latched_byte_sram.sv
module latched_byte_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic [ADDR_W-1:0] addr_lat;
  logic              ce_fall;
  logic              acc_act;
  logic              wr_commit;
  logic [DATA_W-1:0] rd_data_q;

  sram_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i),
    .we_n_i(we_n_i), .addr_lat_o(addr_lat), .ce_fall_o(ce_fall),
    .acc_act_o(acc_act), .wr_commit_o(wr_commit)
  );

  sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_commit), .wr_addr(addr_lat),
    .wr_data(wdata_i), .rd_addr(addr_lat), .rd_data_q(rd_data_q)
  );

  sram_outdrv #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .acc_act(acc_act), .ce_n_i(ce_n_i),
    .oe_n_i(oe_n_i), .we_n_i(we_n_i), .rd_data_q(rd_data_q),
    .drive_o(drive_o), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ce_n_i,
  input logic              we_n_i,
  input logic              oe_n_i,
  input logic              drive_o,
  input logic              ce_fall,
  input logic              wr_commit,
  input logic [ADDR_W-1:0] addr_lat
);
  a_r3_ce_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_i |-> !drive_o);
  a_r4_oe_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !drive_o);
  a_r7_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_i |-> !drive_o);
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall |=> addr_lat == $past(addr_i));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> $stable(addr_lat));
  a_r5_commit_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (!ce_n_i && $past(!ce_n_i)));
  a_r6_drive_cause: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> $past(!ce_n_i && !oe_n_i && we_n_i));
endmodule

bind latched_byte_sram sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i),
  .we_n_i(we_n_i), .oe_n_i(oe_n_i), .drive_o(drive_o),
  .ce_fall(ce_fall), .wr_commit(wr_commit), .addr_lat(addr_lat)
);

// File: tb/latched_byte_sram_tb.sv
module latched_byte_sram_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr_i = '0;
  logic        ce_n_i = 1'b1;
  logic        we_n_i = 1'b1;
  logic        oe_n_i = 1'b1;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        drive_o;

  int total = 0;
  int bad   = 0;

  localparam int NVEC = 8;
  localparam logic [18:0] VEC [NVEC] = '{
    {11'h000, 8'h5A}, {11'h7FF, 8'hA5}, {11'h001, 8'hFF}, {11'h400, 8'h00},
    {11'h3FF, 8'h3C}, {11'h2AA, 8'hC3}, {11'h555, 8'h81}, {11'h123, 8'h7E}
  };

  latched_byte_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i),
    .we_n_i(we_n_i), .oe_n_i(oe_n_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .drive_o(drive_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Write: capture at first edge, address bus reused, commit at we rise.
  task automatic do_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr_i = a; ce_n_i = 0; we_n_i = 1; oe_n_i = 1;
    @(negedge clk); addr_i = ~a; we_n_i = 0; wdata_i = d;
    @(negedge clk); we_n_i = 1;
    @(negedge clk); ce_n_i = 1;
  endtask

  task automatic do_read(input logic [10:0] a, input logic [7:0] e, input string req);
    @(negedge clk); addr_i = a; ce_n_i = 0; we_n_i = 1; oe_n_i = 0;
    @(negedge clk); chk("R6 no drive on capture cycle", drive_o, 0);
    addr_i = a ^ 11'h2B5;
    @(negedge clk); chk("R6 drive", drive_o, 1); chk(req, rdata_o, e);
    ce_n_i = 1; #1;
    chk("R3 ce high cuts drive", drive_o, 0);
    chk("R3 data zero", rdata_o, 0);
    oe_n_i = 1;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1; chk("R9 reset drive", drive_o, 0); chk("R9 reset data", rdata_o, 0);
    #20 rst_n = 1;
    @(negedge clk); chk("R9 after reset drive", drive_o, 0);

    // R1 R2 R5 R6: table of write/read pairs.
    for (int i = 0; i < NVEC; i++) do_write(VEC[i][18:8], VEC[i][7:0]);
    for (int i = 0; i < NVEC; i++) do_read(VEC[i][18:8], VEC[i][7:0], "R1 R2 table readback");

    // R4: output enable toggled inside an access.
    @(negedge clk); addr_i = 11'h7FF; ce_n_i = 0; oe_n_i = 0; we_n_i = 1;
    @(negedge clk); addr_i = 11'h000;
    @(negedge clk); chk("R4 drive before", drive_o, 1);
    oe_n_i = 1; #1; chk("R4 oe high cuts drive", drive_o, 0);
    #1 oe_n_i = 0; #1; chk("R4 drive restored", drive_o, 1);
    chk("R4 data restored", rdata_o, 8'hA5);
    @(negedge clk); ce_n_i = 1; oe_n_i = 1;

    // R7: write pulse with ce high does not change memory.
    @(negedge clk); addr_i = 11'h123; wdata_i = 8'h11; we_n_i = 0;
    @(negedge clk); we_n_i = 1;
    @(negedge clk);
    do_read(11'h123, 8'h7E, "R7 ce-high write ignored");

    // R7 R8: write and read in the same access, oe held low.
    @(negedge clk); addr_i = 11'h2AA; ce_n_i = 0; oe_n_i = 0; we_n_i = 1;
    @(negedge clk); we_n_i = 0; wdata_i = 8'h96; addr_i = 11'h096;
    @(negedge clk); chk("R7 no drive while we low", drive_o, 0);
    we_n_i = 1;
    @(negedge clk); chk("R8 drive after commit", drive_o, 1);
    chk("R8 new byte next cycle", rdata_o, 8'h96);
    ce_n_i = 1; oe_n_i = 1;

    // R1: neighbours undisturbed, R5 target updated.
    do_read(11'h2AA, 8'h96, "R5 committed byte");
    do_read(11'h555, 8'h81, "R1 neighbour kept");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule